// File: doc/BRIEF.md
# Tamper Response Reset Sequencer

This block turns an active-low tamper alarm from user logic into the device's protective response. The alarm only counts once configuration has finished. A qualified alarm is brought into the block's clock domain and latched. From then on the processor and all peripherals are held in reset. Each memory-owning module is then asked to scramble its storage and afterwards to clear it. The modules are served one after another or all at once, as the mode input selects when the sequence starts.

Each module answers every request with an acknowledge. The sequence only moves on once every module it is waiting for has answered. After the final clear acknowledge, the block raises a handled indication toward user logic. It then stays in a cold-reset lockout that nothing but the power-on reset can leave. Warm and cold reset requests reach the block but do not change it.

Top module: `tamper_lockout_seq`

## Requirements
- R1: While `por_n` is low, every output is 0 (no resets, no requests, no handled indication, no lockout). `por_n` acts asynchronously.
- R2: A low `tamper_n` while `cfg_done` is low produces no reset and no request.
- R3: If `tamper_n`=0 and `cfg_done`=1 are sampled at a rising edge, `cpu_rst` and `periph_rst` are 1 after the third rising edge, counting that edge as the first. They are 0 before it, and they stay 1 until `por_n` goes low.
- R4: A qualified tamper level held across a single rising edge is latched. The whole sequence completes even if `tamper_n` returns to 1 at once.
- R5: Serial mode (`serial_mode`=1) serves modules in index order 0 to N-1. For each module it raises the scramble request (`scr_req[i]`) and then the clear request (`clr_req[i]`). At most one request is high at any time.
- R6: Parallel mode (`serial_mode`=0) raises all scramble requests together. It raises all clear requests together only after every scramble acknowledge. Scramble and clear requests are never high in the same cycle.
- R7: A request stays high until its acknowledge is sampled high at a rising edge, and it is low after that edge. Every rising request is preceded by one cycle in which no request is high.
- R8: If the last clear acknowledge is sampled at rising edge k, `handled_ack` and `lockout` become 1 after edge k+1.
- R9: Once `lockout` is 1, it stays 1 together with `handled_ack`, `cpu_rst` and `periph_rst`, with all requests 0, whatever `tamper_n`, `cfg_done`, `serial_mode`, `warm_rst_req` and `cold_rst_req` do. The two reset request inputs also have no effect while idle.
- R10: The mode is taken from `serial_mode` at the edge where the sequence starts. Later changes of `serial_mode` do not alter the order of service.
- R11: An acknowledge from a module whose matching request is low is ignored. This includes a clear acknowledge during the scramble phase.
- R12: Pulsing `por_n` low in lockout returns the block to idle with all outputs 0. A later qualified tamper runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_done | input | 1 | High once device configuration has finished |
| tamper_n | input | 1 | Tamper alarm, active low |
| serial_mode | input | 1 | 1 = serve modules one at a time, 0 = all at once |
| warm_rst_req | input | 1 | Warm reset request, no effect on this block |
| cold_rst_req | input | 1 | Cold reset request, no effect on this block |
| scr_ack | input | N_MEM | Per-module scramble done acknowledge |
| clr_ack | input | N_MEM | Per-module clear done acknowledge |
| scr_req | output | N_MEM | Per-module scramble request |
| clr_req | output | N_MEM | Per-module clear request |
| cpu_rst | output | 1 | Processor reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| handled_ack | output | 1 | Tamper response finished |
| lockout | output | 1 | Permanent cold-reset hold |

## Verification
The resets are due three rising edges after a qualified tamper level is applied: two synchronizer stages and the state register. The bench samples them on the falling edges just before and just after that point. A request must be low on the falling edge after its acknowledge was sampled, and the bench checks it there. `handled_ack` is due one edge after the state that follows the last clear acknowledge. The bench records the falling-edge cycle of that acknowledge and of the rise of `handled_ack`, and requires a gap of exactly two. Power-on reset takes effect at once, so it is checked a few nanoseconds after `por_n` falls, with no clock edge between.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2,
        ST_LOCK = 2'd3
    } seq_state_e;

    typedef enum logic {
        PH_SCRAMBLE = 1'b0,
        PH_CLEAR    = 1'b1
    } wipe_phase_e;

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_target_mask.sv
module tamper_target_mask #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          serial,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  mask
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign mask[i] = !serial || (idx == IW'(i));
    end
endmodule

// File: rtl/tamper_ack_gather.sv
module tamper_ack_gather #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] done_q,
    input  logic [N-1:0] mask,
    output logic [N-1:0] done_d,
    output logic         complete
);
    always_comb begin
        done_d   = done_q | (req & ack);
        complete = ((done_d & mask) == mask);
    end
endmodule

// File: rtl/tamper_lockout_seq.sv
module tamper_lockout_seq
    import tamper_pkg::*;
#(
    parameter int N_MEM       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cfg_done,
    input  logic             tamper_n,
    input  logic             serial_mode,
    input  logic             warm_rst_req,
    input  logic             cold_rst_req,
    input  logic [N_MEM-1:0] scr_ack,
    input  logic [N_MEM-1:0] clr_ack,
    output logic [N_MEM-1:0] scr_req,
    output logic [N_MEM-1:0] clr_req,
    output logic             cpu_rst,
    output logic             periph_rst,
    output logic             handled_ack,
    output logic             lockout
);
    localparam int IW = (N_MEM > 1) ? $clog2(N_MEM) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(N_MEM - 1);

    typedef struct packed {
        seq_state_e      st;
        wipe_phase_e     ph;
        logic [IW-1:0]   idx;
        logic [N_MEM-1:0] done;
        logic            mode;
    } seq_t;

    seq_t seq_d, seq_q;

    // Reset requests are deliberately not part of the state update.
    logic unused_rst_reqs;
    assign unused_rst_reqs = warm_rst_req ^ cold_rst_req;

    // Alarm counts only after configuration has finished.
    logic alarm_raw, alarm_sync;
    assign alarm_raw = cfg_done & ~tamper_n;

    tamper_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .d     (alarm_raw),
        .q     (alarm_sync)
    );

    logic [N_MEM-1:0] target_mask;
    tamper_target_mask #(.N(N_MEM), .IW(IW)) mask_i (
        .serial (seq_q.mode),
        .idx    (seq_q.idx),
        .mask   (target_mask)
    );

    logic [N_MEM-1:0] req_vec, ack_vec, done_next;
    logic             phase_complete;

    assign req_vec = (seq_q.st == ST_REQ) ? (target_mask & ~seq_q.done) : '0;
    assign ack_vec = (seq_q.ph == PH_CLEAR) ? clr_ack : scr_ack;

    tamper_ack_gather #(.N(N_MEM)) gather_i (
        .req      (req_vec),
        .ack      (ack_vec),
        .done_q   (seq_q.done),
        .mask     (target_mask),
        .done_d   (done_next),
        .complete (phase_complete)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (alarm_sync) begin
                    seq_d.st   = ST_REQ;
                    seq_d.ph   = PH_SCRAMBLE;
                    seq_d.idx  = '0;
                    seq_d.done = '0;
                    seq_d.mode = serial_mode;
                end
            end
            ST_REQ: begin
                seq_d.done = done_next;
                if (phase_complete) begin
                    seq_d.st   = ST_GAP;
                    seq_d.done = '0;
                end
            end
            ST_GAP: begin
                if (seq_q.ph == PH_SCRAMBLE) begin
                    seq_d.ph = PH_CLEAR;
                    seq_d.st = ST_REQ;
                end else if (seq_q.mode && (seq_q.idx != LAST_IDX)) begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.ph  = PH_SCRAMBLE;
                    seq_d.st  = ST_REQ;
                end else begin
                    seq_d.st = ST_LOCK;
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q <= '{st: ST_IDLE, ph: PH_SCRAMBLE, idx: '0, done: '0, mode: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scr_req     = (seq_q.ph == PH_SCRAMBLE) ? req_vec : '0;
    assign clr_req     = (seq_q.ph == PH_CLEAR)    ? req_vec : '0;
    assign cpu_rst     = (seq_q.st != ST_IDLE);
    assign periph_rst  = (seq_q.st != ST_IDLE);
    assign handled_ack = (seq_q.st == ST_LOCK);
    assign lockout     = (seq_q.st == ST_LOCK);

    logic mode_latched;
    assign mode_latched = seq_q.mode;
endmodule

// File: rtl/tamper_lockout_chk.sv
module tamper_lockout_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         por_n,
    input logic         mode_latched,
    input logic [N-1:0] scr_req,
    input logic [N-1:0] scr_ack,
    input logic [N-1:0] clr_req,
    input logic [N-1:0] clr_ack,
    input logic         cpu_rst,
    input logic         periph_rst,
    input logic         handled_ack,
    input logic         lockout
);
    a_r3_reset_holds: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst |=> (cpu_rst && periph_rst));

    a_r2_req_only_under_reset: assert property (@(posedge clk) disable iff (!por_n)
        ((|scr_req) || (|clr_req)) |-> (cpu_rst && periph_rst));

    a_r6_phases_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !((|scr_req) && (|clr_req)));

    a_r5_serial_single_req: assert property (@(posedge clk) disable iff (!por_n)
        mode_latched |-> ($countones({scr_req, clr_req}) <= 1));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        lockout |=> (lockout && handled_ack && cpu_rst && scr_req == '0 && clr_req == '0));

    a_r8_lock_after_idle_cycle: assert property (@(posedge clk) disable iff (!por_n)
        $rose(lockout) |-> $past(scr_req == '0 && clr_req == '0));

    for (genvar i = 0; i < N; i++) begin : g_hold
        a_r7_scr_hold: assert property (@(posedge clk) disable iff (!por_n)
            (scr_req[i] && !scr_ack[i]) |=> scr_req[i]);
        a_r7_clr_hold: assert property (@(posedge clk) disable iff (!por_n)
            (clr_req[i] && !clr_ack[i]) |=> clr_req[i]);
        a_r7_scr_drop: assert property (@(posedge clk) disable iff (!por_n)
            (scr_req[i] && scr_ack[i]) |=> !scr_req[i]);
    end
endmodule

bind tamper_lockout_seq tamper_lockout_chk #(.N(N_MEM)) chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .mode_latched (mode_latched),
    .scr_req      (scr_req),
    .scr_ack      (scr_ack),
    .clr_req      (clr_req),
    .clr_ack      (clr_ack),
    .cpu_rst      (cpu_rst),
    .periph_rst   (periph_rst),
    .handled_ack  (handled_ack),
    .lockout      (lockout)
);

// File: tb/tamper_lockout_seq_tb_top.sv
module tamper_lockout_seq_tb_top;
    localparam int N      = 4;
    localparam int MAXLOG = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic por_n, cfg_done, tamper_n, serial_mode, warm_rst_req, cold_rst_req;
    logic [N-1:0] scr_ack, clr_ack, scr_req, clr_req;
    logic cpu_rst, periph_rst, handled_ack, lockout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int log_code [MAXLOG];
    int log_n = 0;
    logic [N-1:0] prev_scr = '0, prev_clr = '0;
    logic [N-1:0] scr_gen = '0, clr_gen = '0;
    int dly_s [N];
    int dly_c [N];
    bit stray_en = 1'b0;
    int last_ack_cyc = 0;
    int handled_cyc = 0;
    logic prev_handled = 1'b0;

    tamper_lockout_seq #(.N_MEM(N)) dut_i (
        .clk(clk), .por_n(por_n), .cfg_done(cfg_done), .tamper_n(tamper_n),
        .serial_mode(serial_mode), .warm_rst_req(warm_rst_req), .cold_rst_req(cold_rst_req),
        .scr_ack(scr_ack), .clr_ack(clr_ack), .scr_req(scr_req), .clr_req(clr_req),
        .cpu_rst(cpu_rst), .periph_rst(periph_rst), .handled_ack(handled_ack), .lockout(lockout)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input bit ser, input int k);
        if (ser) return (k / 2) * 2 + (k % 2);
        return (k % N) * 2 + (k / N);
    endfunction

    function automatic int all_out();
        return {scr_req, clr_req, cpu_rst, periph_rst, handled_ack, lockout};
    endfunction

    // Monitor and memory-module responder, active on falling edges.
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < N; i++) begin
            if (scr_req[i] && !prev_scr[i]) begin
                check((prev_scr | prev_clr) == '0, "R7 idle cycle before scramble request",
                      prev_scr | prev_clr, 0);
                if (log_n < MAXLOG) log_code[log_n] = i * 2;
                log_n++;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (clr_req[i] && !prev_clr[i]) begin
                check((prev_scr | prev_clr) == '0, "R7 idle cycle before clear request",
                      prev_scr | prev_clr, 0);
                if (log_n < MAXLOG) log_code[log_n] = i * 2 + 1;
                log_n++;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (scr_gen[i]) check(!scr_req[i], "R7 scramble request drops after ack", scr_req[i], 0);
            if (clr_gen[i]) check(!clr_req[i], "R7 clear request drops after ack", clr_req[i], 0);
        end
        if (handled_ack && !prev_handled) handled_cyc = cyc;
        prev_handled = handled_ack;
        scr_ack = '0; clr_ack = '0; scr_gen = '0; clr_gen = '0;
        for (int i = 0; i < N; i++) begin
            if (scr_req[i]) begin
                if (dly_s[i] == 0) begin
                    scr_ack[i] = 1'b1; scr_gen[i] = 1'b1; last_ack_cyc = cyc;
                    dly_s[i] = int'($urandom_range(0, 3));
                end else dly_s[i]--;
            end else if (stray_en && $urandom_range(0, 5) == 0) begin
                scr_ack[i] = 1'b1;
            end
            if (clr_req[i]) begin
                if (dly_c[i] == 0) begin
                    clr_ack[i] = 1'b1; clr_gen[i] = 1'b1; last_ack_cyc = cyc;
                    dly_c[i] = int'($urandom_range(0, 3));
                end else dly_c[i]--;
            end else if (stray_en && $urandom_range(0, 5) == 0) begin
                clr_ack[i] = 1'b1;
            end
        end
        prev_scr = scr_req;
        prev_clr = clr_req;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_tamper(input bit mode, input int pulse_len, input bit flip, input bit stray);
        bit locked;
        stray_en = stray;
        log_n = 0;
        step();
        serial_mode = mode; cfg_done = 1'b1; tamper_n = 1'b0;
        for (int c = 1; c <= 4; c++) begin
            step();
            if (c == pulse_len) tamper_n = 1'b1;
            if (c == 2) check(!cpu_rst, "R3 reset not yet due after two edges", cpu_rst, 0);
            if (c == 3) check(cpu_rst && periph_rst, "R3 reset due after third edge",
                              {cpu_rst, periph_rst}, 3);
            if (c == 4 && flip) serial_mode = ~mode;
        end
        tamper_n = 1'b1;
        locked = 1'b0;
        for (int w = 0; w < 3000 && !locked; w++) begin
            step();
            if (flip && w % 3 == 0) serial_mode = ~serial_mode;
            locked = lockout;
        end
        check(locked, "R4 sequence completes after withdrawn tamper", locked, 1);
        check(log_n == 2 * N, mode ? "R5 serial request count" : "R6 parallel request count",
              log_n, 2 * N);
        for (int k = 0; k < 2 * N && k < log_n; k++)
            check(log_code[k] == exp_code(mode, k),
                  mode ? "R5 serial order (R10 captured mode)" : "R6 parallel order (R10 captured mode)",
                  log_code[k], exp_code(mode, k));
        check(handled_cyc - last_ack_cyc == 2, "R8 handled two edges after last ack",
              handled_cyc - last_ack_cyc, 2);
        stray_en = 1'b0;
        for (int c = 0; c < 20; c++) begin
            warm_rst_req = 1'($urandom_range(0, 1));
            cold_rst_req = 1'($urandom_range(0, 1));
            tamper_n     = 1'($urandom_range(0, 1));
            cfg_done     = 1'($urandom_range(0, 1));
            serial_mode  = 1'($urandom_range(0, 1));
            step();
            check(all_out() == 15, "R9 lockout unaffected by inputs", all_out(), 15);
        end
        warm_rst_req = 1'b0; cold_rst_req = 1'b0; tamper_n = 1'b1; cfg_done = 1'b1;
        step();
        check(lockout, "R9 lockout before power-on reset", lockout, 1);
        por_n = 1'b0;
        #3;
        check(all_out() == 0, "R1 R12 power-on reset clears outputs", all_out(), 0);
        step();
        por_n = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            check(all_out() == 0, "R12 idle after power-on reset", all_out(), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd91827));
        for (int i = 0; i < N; i++) begin dly_s[i] = i % 3; dly_c[i] = (i + 1) % 4; end
        por_n = 1'b0; cfg_done = 1'b0; tamper_n = 1'b1; serial_mode = 1'b0;
        warm_rst_req = 1'b0; cold_rst_req = 1'b0; scr_ack = '0; clr_ack = '0;
        #5;
        check(all_out() == 0, "R1 outputs low in power-on reset", all_out(), 0);
        repeat (3) step();
        check(all_out() == 0, "R1 outputs low after clocks in reset", all_out(), 0);
        por_n = 1'b1;

        // R2: alarm before configuration done is ignored
        tamper_n = 1'b0;
        for (int c = 0; c < 25; c++) begin
            step();
            check(all_out() == 0, "R2 tamper ignored before configuration", all_out(), 0);
        end
        tamper_n = 1'b1; cfg_done = 1'b1;
        // R9: reset requests have no effect while idle
        for (int c = 0; c < 10; c++) begin
            warm_rst_req = 1'($urandom_range(0, 1));
            cold_rst_req = 1'($urandom_range(0, 1));
            step();
            check(all_out() == 0, "R9 reset requests ignored while idle", all_out(), 0);
        end
        warm_rst_req = 1'b0; cold_rst_req = 1'b0;

        run_tamper(1'b1, 1, 1'b0, 1'b0);
        run_tamper(1'b0, 2, 1'b1, 1'b0);
        // R11: stray acknowledges must not advance the sequence
        run_tamper(1'b0, 1, 1'b0, 1'b1);
        run_tamper(1'b1, 3, 1'b1, 1'b1);
        for (int r = 0; r < 4; r++)
            run_tamper(1'($urandom_range(0, 1)), int'($urandom_range(1, 4)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        summary();
        $finish;
    end
endmodule